// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one data character at a time into an asynchronous serial frame on a single output line. A character enters through a valid/ready handshake. The frame settings are captured at that moment: character width (5 to 8 bits), long or short stop period, parity on or off, parity sense, and forced parity. The frame is then a low start bit, the data bits least significant first, an optional parity bit, and a high stop period. A line-break control works on the live output and pulls the line low while it is set. The block is used behind a baud-rate generator that supplies a single-cycle enable strobe at sixteen times the bit rate.

Every bit lasts sixteen strobes. The stop period lasts sixteen strobes in short mode. In long mode it lasts twenty-four strobes for 5-bit characters and thirty-two for all wider characters. The line rests high between frames. Break overrides only the line. The frame sequencer keeps counting while break is set, so the line shows the bit then in progress as soon as break drops.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is clear, `tx` is 1 and `in_ready` is 1.
- R2: A frame starts with one start bit at 0, followed by the data bits least significant first. `cfg_wlen` selects the count of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of `in_data` are not sent. Each bit lasts 16 `tick_16x` strobes.
- R3: With `cfg_stop` = 0 the stop period is one bit at 1, lasting 16 strobes, for every character width.
- R4: With `cfg_stop` = 1 the stop period lasts 24 strobes (1.5 bits) when `cfg_wlen` = 00. It lasts 32 strobes (2 bits) for the other widths.
- R5: With `cfg_par_en` = 0, no parity bit is sent. The stop period follows the last data bit directly.
- R6: With `cfg_par_en` = 1 and `cfg_par_force` = 0, a parity bit follows the data. When `cfg_par_type` = 0, the count of 1s across data and parity is odd. When `cfg_par_type` = 1, that count is even.
- R7: With `cfg_par_en` = 1 and `cfg_par_force` = 1, the parity bit is 1 when `cfg_par_type` = 0 and 0 when `cfg_par_type` = 1, whatever the data.
- R8: While `cfg_break` is 1, `tx` is 0 one clock later. Frame timing is unaffected. After break is cleared, `tx` shows the bit currently in progress.
- R9: A character is accepted on a clock where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next clock until the strobe that ends the stop period. `in_valid` has no effect while `in_ready` is 0.
- R10: The frame settings and data are captured at acceptance. Changes to `cfg_wlen`, `cfg_stop`, `cfg_par_en`, `cfg_par_type`, `cfg_par_force` or `in_data` during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | Enable strobe at 16x bit rate |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can accept a character |
| in_data | input | 8 | Character to send |
| cfg_wlen | input | 2 | Data bit count select |
| cfg_stop | input | 1 | Long stop period select |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_type | input | 1 | Parity sense / forced value select |
| cfg_par_force | input | 1 | Forced parity enable |
| cfg_break | input | 1 | Hold line low |
| tx | output | 1 | Serial line |

## Verification
The hardest case to reach from the ports is a frame whose settings change while it is on the line. The bench changes every frame setting and the data just after acceptance, and it also holds `in_valid` high during the frame. It then checks that every bit and the frame length still follow the captured settings. A second hard case is a break that starts and ends inside a frame. The bench raises `cfg_break` at chosen strobe counts and checks two things: the line reads low in between, and the mid-bit samples after release and the `in_ready` return still land on the strobe counts of an undisturbed frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } phase_t;

    typedef struct packed {
        logic [1:0] wlen;
        logic       stop_long;
        logic       par_en;
        logic       par_type;
        logic       par_force;
    } line_cfg_t;

    function automatic logic [2:0] last_bit_idx(input logic [1:0] wlen);
        return 3'd4 + {1'b0, wlen};
    endfunction

    function automatic logic [DATA_W-1:0] mask_data(input logic [DATA_W-1:0] d,
                                                    input logic [1:0] wlen);
        logic [DATA_W-1:0] m;
        case (wlen)
            2'b00:   m = 8'h1F;
            2'b01:   m = 8'h3F;
            2'b10:   m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return d & m;
    endfunction

    function automatic logic parity_value(input logic [DATA_W-1:0] masked,
                                          input line_cfg_t c);
        if (c.par_force)
            return ~c.par_type;
        return (^masked) ^ ~c.par_type;
    endfunction

    function automatic int unsigned stop_ticks(input line_cfg_t c, input int unsigned tpb);
        if (!c.stop_long)
            return tpb;
        if (c.wlen == 2'b00)
            return tpb + tpb / 2;
        return 2 * tpb;
    endfunction

endpackage

// File: rtl/sertx_baud_cnt.sv
module sertx_baud_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    assign last = tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick)
            cnt <= last ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/sertx_frame_seq.sv
module sertx_frame_seq
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int CNT_W         = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  line_cfg_t         cfg_in,
    input  logic              bit_done,
    output logic              in_ready,
    output logic              restart,
    output logic [CNT_W-1:0]  limit,
    output logic              line_bit
);
    phase_t            phase;
    line_cfg_t         cfg_q;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic [2:0]        bidx;
    logic [DATA_W-1:0] masked_in;

    assign in_ready  = (phase == PH_IDLE);
    assign restart   = in_valid && in_ready;
    assign masked_in = mask_data(in_data, cfg_in.wlen);

    always_comb begin
        if (phase == PH_STOP)
            limit = CNT_W'(stop_ticks(cfg_q, TICKS_PER_BIT));
        else
            limit = CNT_W'(TICKS_PER_BIT);
    end

    always_comb begin
        case (phase)
            PH_START:  line_bit = 1'b0;
            PH_DATA:   line_bit = shreg[0];
            PH_PARITY: line_bit = par_q;
            default:   line_bit = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cfg_q <= '0;
            shreg <= '0;
            par_q <= 1'b0;
            bidx  <= '0;
        end else if (restart) begin
            phase <= PH_START;
            cfg_q <= cfg_in;
            shreg <= masked_in;
            par_q <= parity_value(masked_in, cfg_in);
            bidx  <= '0;
        end else if (bit_done) begin
            case (phase)
                PH_START: begin
                    phase <= PH_DATA;
                    bidx  <= '0;
                end
                PH_DATA: begin
                    shreg <= shreg >> 1;
                    bidx  <= bidx + 1'b1;
                    if (bidx == last_bit_idx(cfg_q.wlen))
                        phase <= cfg_q.par_en ? PH_PARITY : PH_STOP;
                end
                PH_PARITY: phase <= PH_STOP;
                PH_STOP:   phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sertx_line_out.sv
module sertx_line_out (
    input  logic clk,
    input  logic rst,
    input  logic line_bit,
    input  logic force_low,
    output logic tx
);
    always_ff @(posedge clk) begin
        if (rst)
            tx <= 1'b1;
        else
            tx <= force_low ? 1'b0 : line_bit;
    end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_16x,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_stop,
    input  logic       cfg_par_en,
    input  logic       cfg_par_type,
    input  logic       cfg_par_force,
    input  logic       cfg_break,
    output logic       tx
);
    localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);

    line_cfg_t        cfg_in;
    logic             bit_done;
    logic             restart;
    logic [CNT_W-1:0] limit;
    logic             line_bit;

    assign cfg_in = '{wlen:      cfg_wlen,
                      stop_long: cfg_stop,
                      par_en:    cfg_par_en,
                      par_type:  cfg_par_type,
                      par_force: cfg_par_force};

    sertx_baud_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_16x),
        .restart (restart),
        .limit   (limit),
        .last    (bit_done)
    );

    sertx_frame_seq #(.TICKS_PER_BIT(TICKS_PER_BIT), .CNT_W(CNT_W)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .cfg_in   (cfg_in),
        .bit_done (bit_done),
        .in_ready (in_ready),
        .restart  (restart),
        .limit    (limit),
        .line_bit (line_bit)
    );

    sertx_line_out line_i (
        .clk       (clk),
        .rst       (rst),
        .line_bit  (line_bit),
        .force_low (cfg_break),
        .tx        (tx)
    );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst,
    input logic tick_16x,
    input logic in_valid,
    input logic in_ready,
    input logic cfg_break,
    input logic tx
);
    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !cfg_break) |=> tx);

    // R8
    break_low_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_break |=> !tx);

    // R9
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R2
    start_bit_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !cfg_break) ##1 !cfg_break |=> !tx);

    // R3
    ready_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> $past(tick_16x));
endmodule

bind sertx_top sertx_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick_16x  (tick_16x),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .cfg_break (cfg_break),
    .tx        (tx)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16x = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic [1:0] cfg_wlen = '0;
    logic       cfg_stop = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_type = 1'b0;
    logic       cfg_par_force = 1'b0;
    logic       cfg_break = 1'b0;
    logic       tx;

    int checks = 0;
    int errors = 0;
    int div = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        div      <= (div == TICK_DIV - 1) ? 0 : div + 1;
        tick_16x <= (div == TICK_DIV - 1);
    end

    sertx_top dut_i (
        .clk           (clk),
        .rst           (rst),
        .tick_16x      (tick_16x),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .cfg_wlen      (cfg_wlen),
        .cfg_stop      (cfg_stop),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_type  (cfg_par_type),
        .cfg_par_force (cfg_par_force),
        .cfg_break     (cfg_break),
        .tx            (tx)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [7:0] d, input logic [1:0] wl, input logic st,
                             input logic pe, input logic pt, input logic pf,
                             input int brk_lo, input int brk_hi, input bit mess);
        int   nb, nslots, stp, total, t, ones;
        logic exp_bits [0:11];
        logic pbit;
        string rq;
        nb = 5 + int'(wl);
        ones = 0;
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        if (pf) pbit = ~pt;
        else    pbit = pt ? logic'(ones % 2) : logic'(~(ones % 2));
        exp_bits[0] = 1'b0;
        for (int i = 0; i < nb; i++) exp_bits[i + 1] = d[i];
        nslots = 1 + nb;
        if (pe) begin
            exp_bits[nslots] = pbit;
            nslots++;
        end
        if (!st)          stp = 16;
        else if (wl == 0) stp = 24;
        else              stp = 32;
        total = 16 * nslots + stp;

        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data = d; cfg_wlen = wl; cfg_stop = st;
        cfg_par_en = pe; cfg_par_type = pt; cfg_par_force = pf;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready, 1'b0, "R9", "ready after accept");
        t = 0;
        while (t < total) begin
            logic tk;
            @(posedge clk);
            tk = tick_16x;
            @(negedge clk);
            if (tk) begin
                bit brk;
                t++;
                brk = (t > brk_lo) && (t <= brk_hi);
                if ((t % 16) == 8 && (t / 16) < nslots) begin
                    int k;
                    k = t / 16;
                    if (brk)            rq = "R8";
                    else if (mess)      rq = "R10";
                    else if (k == 0)    rq = "R2";
                    else if (k <= nb)   rq = "R2";
                    else if (pf)        rq = "R7";
                    else                rq = "R6";
                    chk(tx, brk ? 1'b0 : exp_bits[k], rq, $sformatf("slot %0d wl %0d", k, wl));
                end
                if (t == 16 * nslots + 4 || t == total - 4) begin
                    rq = pe ? "R3" : "R5";
                    chk(tx, brk ? 1'b0 : 1'b1, brk ? "R8" : rq, "stop level");
                end
                if (t == total - 1)
                    chk(in_ready, 1'b0, st ? "R4" : "R3", $sformatf("busy before end, stop %0d", stp));
                if (t == total) begin
                    chk(in_ready, 1'b1, st ? "R4" : "R3", $sformatf("ready at end, stop %0d", stp));
                    if (mess) in_valid = 1'b0;
                end
                if (t == brk_lo) cfg_break = 1'b1;
                if (t == brk_hi) cfg_break = 1'b0;
                if (mess && t == 2) begin
                    in_data = ~d; cfg_wlen = ~wl; cfg_stop = ~st;
                    cfg_par_en = ~pe; cfg_par_type = ~pt; cfg_par_force = ~pf;
                    in_valid = 1'b1;
                end
                if (mess && t == total - 2) in_valid = 1'b0;
            end
        end
        cfg_break = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx, 1'b1, "R1", "idle tx after reset");
        chk(in_ready, 1'b1, "R1", "ready after reset");

        cfg_break = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx, 1'b0, "R8", "break while idle");
        cfg_break = 1'b0;
        repeat (2) @(negedge clk);
        chk(tx, 1'b1, "R1", "idle after break release");

        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 2; s++)
                for (int p = 0; p < 5; p++)
                    for (int v = 0; v < 2; v++) begin
                        logic [7:0] dv;
                        dv = (v == 0) ? 8'hA5 : (8'h3C ^ 8'(w * 17 + p * 3 + s));
                        run_frame(dv, 2'(w), s[0], (p != 0), (p == 2 || p == 4), (p >= 3),
                                  -1, -1, 1'b0);
                    end

        run_frame(8'h96, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 20, 60, 1'b0);
        run_frame(8'h0F, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 5, 100, 1'b0);
        run_frame(8'hC3, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, -1, -1, 1'b1);
        run_frame(8'h5A, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, -1, -1, 1'b1);

        repeat (8) @(negedge clk);
        chk(tx, 1'b1, "R1", "idle after frames");
        chk(in_ready, 1'b1, "R9", "no stray accept");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule